// File: doc/BRIEF.md
# Selectable edge clock-enable generator

This block produces the count-enable strobe for a timer. The strobe either follows every system clock or is derived from one chosen edge on one of four external, asynchronous pins. A single 4-bit selector picks both the pin and the edge polarity. A 2-bit mode value picks how the strobe is formed. All logic runs in the system-clock domain.

The block also conditions the same four pins for use as timer events. A per-pin enable bit routes a pin through a two-flop synchronizer, or lets it through raw for lower latency. The pin chosen as the count source always goes through the synchronizer, whatever its enable bit says. Edges are found by comparing each synchronized level with a registered copy of the previous cycle.

Top module: `edge_clken_gen`

## Requirements
- R1: While reset is asserted, `cnt_en_o` is 0, and every event output whose sync bit is 1 reads 0.
- R2: In mode 0 (free) and mode 3 (treated as free), `cnt_en_o` is 1 on every cycle after the first clock edge out of reset.
- R3: Selector value 2n picks rising edges of pin n, and value 2n+1 picks falling edges of pin n, for n = 0..3. An edge of the other polarity, or an edge on another pin, gives no strobe.
- R4: In mode 2 (edge-sourced), a level change applied to the selected pin before clock edge k gives a one-cycle `cnt_en_o` pulse in the cycle after edge k+1.
- R5: In mode 1 (gated), the same change gives a one-cycle `cnt_en_o` pulse one cycle later than in mode 2, in the cycle after edge k+2.
- R6: Selector values 8 to 15 are reserved and give no strobe in mode 1 or mode 2.
- R7: A pin pulse one system-clock period wide is detected and gives exactly one strobe cycle.
- R8: When a pin's sync bit is 1, its event output follows the pin after two clock edges.
- R9: When a pin's sync bit is 0, its event output follows the pin with no clock delay.
- R10: The count-source path is synchronized even when the selected pin's sync bit is 0, so its strobe timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 4 | Asynchronous external pins |
| mode_i | input | 2 | 0 free, 1 gated by edge, 2 edge-sourced, 3 treated as 0 |
| edge_sel_i | input | 4 | Bit 0 is polarity (1 = falling), bits 2:1 are the pin index, bit 3 set means reserved |
| sync_en_i | input | 4 | Per-pin event synchronizer enable (bit n for pin n) |
| cnt_en_o | output | 1 | Count-enable strobe |
| evt_o | output | 4 | Conditioned event inputs |

## Verification
A count strobe and an event change on the same synchronized pin can land in the same cycle. This happens in mode 2 when that pin's sync bit is set, because both come out of the same second flop. The bench provokes it with a rising step on pin 0 under selector 0. It then checks that `cnt_en_o` and `evt_o[0]` are both low one edge after the step and both high after the second edge. A bypassed pin, by contrast, must show its event at once while its strobe keeps the synchronized timing.

// File: rtl/clken_pkg.sv
package clken_pkg;
    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_GATED = 2'd1,
        MODE_EDGE  = 2'd2,
        MODE_ALIAS = 2'd3
    } clk_mode_e;

    localparam int unsigned DEF_PINS  = 4;
    localparam int unsigned DEF_SEL_W = 4;
endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
    parameter int unsigned NUM_PINS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] sync_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] s1;
        logic [NUM_PINS-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pins_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R8: the second stage always repeats the first stage of the cycle before
    a_r8_two_stage : assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (sync_o == $past(st_q.s1)));
endmodule

// File: rtl/edge_pick.sv
module edge_pick #(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned SEL_W    = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                edge_o
);
    localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
    } hist_t;

    hist_t h_d, h_q;
    logic [NUM_PINS-1:0] rise, fall;
    logic [IDX_W-1:0]    idx;
    logic                pol, sel_ok;

    always_comb begin
        h_d      = h_q;
        h_d.prev = sync_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) h_q <= '0;
        else         h_q <= h_d;
    end

    assign rise   = sync_i & ~h_q.prev;
    assign fall   = ~sync_i & h_q.prev;
    assign pol    = sel_i[0];
    assign idx    = sel_i[IDX_W:1];
    assign sel_ok = ((sel_i >> (IDX_W + 1)) == '0) && (32'(idx) < NUM_PINS);

    always_comb begin
        edge_o = 1'b0;
        if (sel_ok) edge_o = pol ? fall[idx] : rise[idx];
    end

    // R6: reserved selector never gives a strobe
    a_r6_reserved_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i[SEL_W-1]) |-> !edge_o);
    // R7: one edge of one polarity gives exactly one strobe cycle
    a_r7_single_cycle : assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> (!edge_o || !$stable(sel_i)));
endmodule

// File: rtl/edge_clken_gen.sv
module edge_clken_gen
    import clken_pkg::*;
#(
    parameter int unsigned NUM_PINS = DEF_PINS,
    parameter int unsigned SEL_W    = DEF_SEL_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [1:0]          mode_i,
    input  logic [SEL_W-1:0]    edge_sel_i,
    input  logic [NUM_PINS-1:0] sync_en_i,
    output logic                cnt_en_o,
    output logic [NUM_PINS-1:0] evt_o
);
    typedef struct packed {
        logic en;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic                edge_hit;

    pin_sync_bank #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins_i),
        .sync_o (pin_sync)
    );

    edge_pick #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_pick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (pin_sync),
        .sel_i  (edge_sel_i),
        .edge_o (edge_hit)
    );

    always_comb begin
        c_d = c_q;
        case (mode_i)
            MODE_GATED: c_d.en = edge_hit;
            MODE_EDGE:  c_d.en = 1'b0;
            default:    c_d.en = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign cnt_en_o = (mode_i == MODE_EDGE) ? edge_hit : c_q.en;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_evt
        assign evt_o[g] = sync_en_i[g] ? pin_sync[g] : pins_i[g];
    end

    // R2: free (and aliased) mode keeps the strobe high
    a_r2_free_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_FREE || mode_i == MODE_ALIAS) |=> (mode_i == MODE_EDGE || cnt_en_o));
    // R5: gated strobe follows a detected edge by one cycle
    a_r5_gated_delay : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_GATED && edge_hit) |=> (mode_i != MODE_GATED || cnt_en_o));
    // R4: edge-sourced mode strobes only on a detected edge
    a_r4_edge_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_EDGE && !edge_hit) |-> !cnt_en_o);
    // R1: reset holds the strobe low
    always_comb begin
        if (!rst_ni) a_r1_reset_quiet : assert (c_q.en == 1'b0);
    end
endmodule

// File: tb/edge_clken_gen_bench.sv
module edge_clken_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pins;
    logic [1:0] mode;
    logic [3:0] sel;
    logic [3:0] sync_en;
    logic       cnt_en;
    logic [3:0] evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    edge_clken_gen u_edge_clken_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pins_i     (pins),
        .mode_i     (mode),
        .edge_sel_i (sel),
        .sync_en_i  (sync_en),
        .cnt_en_o   (cnt_en),
        .evt_o      (evt)
    );

    // {mode, sel, pins before, pins after, strobe after 2 edges, strobe after 3 edges}
    localparam logic [15:0] VEC [12] = '{
        {2'd2, 4'd0, 4'b0000, 4'b0001, 1'b1, 1'b0},  // R4 R3 rise pin0
        {2'd1, 4'd0, 4'b0000, 4'b0001, 1'b0, 1'b1},  // R5 gated rise pin0
        {2'd2, 4'd1, 4'b0001, 4'b0000, 1'b1, 1'b0},  // R3 fall pin0
        {2'd2, 4'd1, 4'b0000, 4'b0001, 1'b0, 1'b0},  // R3 wrong polarity
        {2'd1, 4'd6, 4'b0000, 4'b1000, 1'b0, 1'b1},  // R3 rise pin3
        {2'd2, 4'd4, 4'b0000, 4'b0001, 1'b0, 1'b0},  // R3 other pin
        {2'd1, 4'd5, 4'b0100, 4'b0000, 1'b0, 1'b1},  // R3 fall pin2
        {2'd2, 4'd9, 4'b0000, 4'b1111, 1'b0, 1'b0},  // R6 reserved
        {2'd1, 4'd8, 4'b1111, 4'b0000, 1'b0, 1'b0},  // R6 reserved
        {2'd0, 4'd0, 4'b0000, 4'b0000, 1'b1, 1'b1},  // R2 free
        {2'd3, 4'd3, 4'b0000, 4'b0010, 1'b1, 1'b1},  // R2 alias of free
        {2'd1, 4'd3, 4'b0010, 4'b0000, 1'b0, 1'b1}   // R3 R5 fall pin1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        pins    = 4'b1111;
        mode    = 2'd0;
        sel     = 4'd0;
        sync_en = 4'b1111;
        negs(3);
        chk("R1 strobe in reset", 32'(cnt_en), 32'd0);
        chk("R1 synced events in reset", 32'(evt), 32'd0);
        pins = 4'b0000;
        negs(1);
        rst_n = 1'b1;
        negs(1);
        chk("R2 free after reset", 32'(cnt_en), 32'd1);

        // vector table
        for (int v = 0; v < 12; v++) begin
            mode = VEC[v][15:14];
            sel  = VEC[v][13:10];
            pins = VEC[v][9:6];
            negs(5);
            pins = VEC[v][5:2];
            negs(2);
            chk($sformatf("R3/R4/R5 vec%0d after 2 edges", v), 32'(cnt_en), 32'(VEC[v][1]));
            negs(1);
            chk($sformatf("R3/R4/R5 vec%0d after 3 edges", v), 32'(cnt_en), 32'(VEC[v][0]));
        end

        // R7: one-period pulse, mode 1, rising on pin 0
        mode = 2'd1; sel = 4'd0; pins = 4'b0000;
        negs(5);
        pins = 4'b0001;
        negs(1);
        pins = 4'b0000;
        negs(2);
        chk("R7 narrow pulse strobe", 32'(cnt_en), 32'd1);
        negs(1);
        chk("R7 single strobe cycle", 32'(cnt_en), 32'd0);

        // R9: bypassed events follow pins at once
        sync_en = 4'b0000;
        negs(1);
        pins = 4'b1010;
        #1;
        chk("R9 bypass immediate", 32'(evt), 32'hA);
        negs(4);
        // R8: synchronized events lag by two edges
        sync_en = 4'b1111;
        #1;
        chk("R8 synced holds old", 32'(evt), 32'hA);
        pins = 4'b0101;
        negs(1);
        chk("R8 synced after 1 edge", 32'(evt), 32'hA);
        negs(1);
        chk("R8 synced after 2 edges", 32'(evt), 32'h5);

        // R10: count source stays synchronized when bypassed for events
        mode = 2'd2; sel = 4'd0; sync_en = 4'b0000; pins = 4'b0000;
        negs(5);
        pins = 4'b0001;
        negs(1);
        chk("R10 no early strobe", 32'(cnt_en), 32'd0);
        negs(1);
        chk("R10 strobe after 2 edges", 32'(cnt_en), 32'd1);

        // coincidence: strobe and synced event in the same cycle (R4, R8)
        sync_en = 4'b1111; pins = 4'b0000;
        negs(5);
        pins = 4'b0001;
        negs(1);
        chk("R4 coincide strobe low", 32'(cnt_en), 32'd0);
        chk("R8 coincide event low", 32'(evt[0]), 32'd0);
        negs(1);
        chk("R4 coincide strobe high", 32'(cnt_en), 32'd1);
        chk("R8 coincide event high", 32'(evt[0]), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule